// File: doc/BRIEF.md
# Trapping Two's-Complement Adder-Subtractor

This block is the add/subtract unit of an integer datapath. It takes two operands, an add or subtract select, a trap-enable select and the program counter of the operation. It produces the wrapped sum or difference, the carry out of the adder and a signed-overflow flag. Subtraction uses the same adder. The second operand is inverted and the carry-in is forced to one. The adder is built from lookahead groups, and the carry skips between groups.

Operations without trapping always wrap quietly. When trapping is enabled and an operation overflows, four things happen. The result is still driven, but its write enable is withdrawn. The block raises a one-cycle exception request. It stores the program counter of that operation in an exception PC register, which can be read back at any time. It also offers a fixed handler address as the redirect target.

Operands arrive on a valid/ready stream. The output stream returns the result in the same cycle, so `in_ready` simply mirrors `out_ready`, and `out_valid` mirrors `in_valid`. An operation is consumed only in a cycle where both `in_valid` and `out_ready` are high. While `out_ready` is low, the inputs must be held steady. A stalled operation raises no exception request and does not touch the exception PC, even when it overflows in trapping mode.

Top module: `trap_addsub`

## Requirements
- R1: With op_sub=0, result equals op_a+op_b modulo 2^32, and carry_out is bit 32 of the unsigned sum.
- R2: With op_sub=1, result equals op_a-op_b modulo 2^32, and carry_out is the carry of op_a + ~op_b + 1 (1 means no borrow).
- R3: For addition, overflow is 0 when the operand sign bits (bit 31) differ. When the signs are equal, overflow is 1 exactly when the result sign differs from them.
- R4: For subtraction, overflow is 0 when the operand signs are equal. When they differ, overflow is 1 exactly when the result sign differs from the sign of op_a.
- R5: With trap_en=0, the result is the wrapped value, wr_en equals in_valid, exc_req stays 0 and epc_out does not change, even on overflow.
- R6: With trap_en=1 and an overflowing operation that is accepted, exc_req is 1 in that same cycle. In that cycle wr_en is 0 and result still carries the wrapped value.
- R7: After an accepted trapping overflow, epc_out holds that operation's pc_in from the next cycle on. In every other cycle epc_out holds its value.
- R8: While rst_n is low, epc_out is 0 and exc_req is 0.
- R9: handler_pc always equals the HANDLER_ADDR parameter (default 32'h8000_0180).
- R10: in_ready equals out_ready and out_valid equals in_valid. With out_ready=0, exc_req stays 0 and epc_out is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_ready | output | 1 | Operation can be consumed this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| trap_en | input | 1 | 1 = overflow raises an exception |
| pc_in | input | 32 | Program counter of the operation |
| out_valid | output | 1 | Result present on the outputs |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | 32 | Wrapped sum or difference |
| carry_out | output | 1 | Unsigned carry out of the adder |
| overflow | output | 1 | Signed overflow of this operation |
| wr_en | output | 1 | Result may be written back |
| exc_req | output | 1 | One-cycle exception request |
| handler_pc | output | 32 | Fixed redirect target |
| epc_out | output | 32 | Captured exception PC |

## Verification
The bench builds the block with its defaults: a 32-bit width, 4-bit lookahead groups and a handler address of 32'h8000_0180. That gives eight groups, so operands such as 32'h7fff_ffff + 1 push a carry through every group boundary and the skip path. The sign-boundary operands reach each of the four overflow cases and the two cases that can never overflow. With these defaults the handler and exception PC values can be compared directly against full 32-bit constants.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int          DEF_WIDTH   = 32;
  localparam int          DEF_GROUP   = 4;
  localparam logic [31:0] DEF_HANDLER = 32'h8000_0180;

  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} op_kind_e;
endpackage

// File: rtl/cla_group.sv
module cla_group #(
  parameter int BW = 4
) (
  input  logic [BW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  input  logic          c_i,
  output logic [BW-1:0] s_o,
  output logic          c_o
);
  logic [BW-1:0] gen_v;
  logic [BW-1:0] prop_v;
  logic          grp_gen;
  logic          grp_prop;
  logic          ripple_c;

  assign gen_v  = a_i & b_i;
  assign prop_v = a_i ^ b_i;

  always_comb begin
    ripple_c = c_i;
    for (int i = 0; i < BW; i++) begin
      s_o[i]   = prop_v[i] ^ ripple_c;
      ripple_c = gen_v[i] | (prop_v[i] & ripple_c);
    end
  end

  always_comb begin
    grp_gen = 1'b0;
    for (int i = 0; i < BW; i++) begin
      grp_gen = gen_v[i] | (prop_v[i] & grp_gen);
    end
    grp_prop = &prop_v;
  end

  assign c_o = grp_gen | (grp_prop & c_i);

  always_comb begin
    // R1
    skip_carry_chk: assert (c_o == ripple_c);
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NGRP = WIDTH / GROUP;

  logic [WIDTH-1:0] b_eff;
  logic [NGRP:0]    chain;

  assign b_eff    = b_i ^ {WIDTH{sub_i}};
  assign chain[0] = sub_i;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    cla_group #(.BW(GROUP)) u_grp (
      .a_i (a_i[gi*GROUP +: GROUP]),
      .b_i (b_eff[gi*GROUP +: GROUP]),
      .c_i (chain[gi]),
      .s_o (sum_o[gi*GROUP +: GROUP]),
      .c_o (chain[gi+1])
    );
  end

  assign cout_o = chain[NGRP];

  always_comb begin
    // R1 R2
    sum_value_chk: assert (sum_o == (sub_i ? (a_i - b_i) : (a_i + b_i)));
  end
endmodule

// File: rtl/ovf_detect.sv
module ovf_detect (
  input  logic a_sign,
  input  logic b_sign,
  input  logic r_sign,
  input  logic sub_i,
  output logic ovf_o
);
  logic same_sign;
  logic flipped;

  assign same_sign = (a_sign == b_sign);
  assign flipped   = (r_sign != a_sign);

  always_comb begin
    if (sub_i) ovf_o = !same_sign && flipped;
    else       ovf_o = same_sign && flipped;
  end
endmodule

// File: rtl/epc_capture.sv
module epc_capture #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] pc_i,
  output logic [WIDTH-1:0] epc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      epc_o <= '0;
    else if (cap_en) epc_o <= pc_i;
  end
endmodule

// File: rtl/trap_addsub.sv
module trap_addsub
  import addsub_pkg::*;
#(
  parameter int               WIDTH        = DEF_WIDTH,
  parameter int               GROUP        = DEF_GROUP,
  parameter logic [WIDTH-1:0] HANDLER_ADDR = DEF_HANDLER
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             op_sub,
  input  logic             trap_en,
  input  logic [WIDTH-1:0] pc_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow,
  output logic             wr_en,
  output logic             exc_req,
  output logic [WIDTH-1:0] handler_pc,
  output logic [WIDTH-1:0] epc_out
);
  localparam int MSB = WIDTH - 1;

  op_kind_e op_kind;
  logic     accept;
  logic     trap_hit;

  assign op_kind = op_sub ? OP_SUB : OP_ADD;

  addsub_core #(.WIDTH(WIDTH), .GROUP(GROUP)) u_core (
    .a_i    (op_a),
    .b_i    (op_b),
    .sub_i  (op_kind == OP_SUB),
    .sum_o  (result),
    .cout_o (carry_out)
  );

  ovf_detect u_ovf (
    .a_sign (op_a[MSB]),
    .b_sign (op_b[MSB]),
    .r_sign (result[MSB]),
    .sub_i  (op_kind == OP_SUB),
    .ovf_o  (overflow)
  );

  assign in_ready   = out_ready;
  assign out_valid  = in_valid;
  assign accept     = in_valid && out_ready;
  assign trap_hit   = trap_en && overflow;
  assign wr_en      = in_valid && !trap_hit;
  assign exc_req    = rst_n && accept && trap_hit;
  assign handler_pc = HANDLER_ADDR;

  epc_capture #(.WIDTH(WIDTH)) u_epc (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (exc_req),
    .pc_i   (pc_in),
    .epc_o  (epc_out)
  );

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sub && (op_a[MSB] != op_b[MSB])) |-> !overflow);
  // R4
  sub_same_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sub && (op_a[MSB] == op_b[MSB])) |-> !overflow);
  // R6
  trap_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (!wr_en && overflow && trap_en && in_valid));
  // R7
  epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (epc_out == $past(pc_in)));
  // R7
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |=> $stable(epc_out));
  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !exc_req);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (epc_out == '0));
endmodule

// File: tb/trap_addsub_tb.sv
module trap_addsub_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  localparam logic [31:0] VA [0:NV-1] = '{
    32'h0000_0007, 32'h0000_0007, 32'h7fff_ffff, 32'h8000_0000, 32'h7fff_ffff,
    32'h7fff_ffff, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 32'hffff_ffff};
  localparam logic [31:0] VB [0:NV-1] = '{
    32'h0000_0006, 32'h0000_0006, 32'h0000_0001, 32'hffff_ffff, 32'h8000_0000,
    32'hffff_ffff, 32'h0000_0001, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001};
  localparam logic VS [0:NV-1] = '{0, 1, 0, 0, 0, 1, 1, 1, 1, 0};
  localparam logic [31:0] VR [0:NV-1] = '{
    32'h0000_000d, 32'h0000_0001, 32'h8000_0000, 32'h7fff_ffff, 32'hffff_ffff,
    32'h8000_0000, 32'h7fff_ffff, 32'h0000_0000, 32'hffff_ffff, 32'h0000_0000};
  localparam logic VO [0:NV-1] = '{0, 0, 1, 1, 0, 1, 1, 0, 0, 0};
  localparam logic VC [0:NV-1] = '{0, 1, 0, 1, 0, 0, 1, 1, 0, 1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        op_sub = 1'b0;
  logic        trap_en = 1'b0;
  logic [31:0] pc_in = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] result;
  logic        carry_out;
  logic        overflow;
  logic        wr_en;
  logic        exc_req;
  logic [31:0] handler_pc;
  logic [31:0] epc_out;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_addsub dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .op_sub(op_sub), .trap_en(trap_en), .pc_in(pc_in),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .carry_out(carry_out), .overflow(overflow), .wr_en(wr_en), .exc_req(exc_req),
    .handler_pc(handler_pc), .epc_out(epc_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic s,
                       input logic t, input logic [31:0] pc, input logic v, input logic rdy);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = s; trap_en = t; pc_in = pc;
    in_valid = v; out_ready = rdy;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R8 epc in reset", epc_out, 32'h0);
    check("R8 exc in reset", {31'b0, exc_req}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VA[i], VB[i], VS[i], 1'b0, 32'h100 + 32'(i) * 4, 1'b1, 1'b1);
      check(VS[i] ? "R2 result" : "R1 result", result, VR[i]);
      check(VS[i] ? "R2 carry" : "R1 carry", {31'b0, carry_out}, {31'b0, VC[i]});
      check(VS[i] ? "R4 overflow" : "R3 overflow", {31'b0, overflow}, {31'b0, VO[i]});
      check("R5 wr_en", {31'b0, wr_en}, 32'h1);
      check("R5 exc_req", {31'b0, exc_req}, 32'h0);
      check("R10 out_valid", {31'b0, out_valid}, 32'h1);
    end
    drive('0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    check("R5 epc untouched", epc_out, 32'h0);
    check("R5 wr_en idle", {31'b0, wr_en}, 32'h0);

    // R6 trapping overflow
    drive(32'h7fff_ffff, 32'h1, 1'b0, 1'b1, 32'h0000_0400, 1'b1, 1'b1);
    check("R6 exc_req", {31'b0, exc_req}, 32'h1);
    check("R6 wr_en", {31'b0, wr_en}, 32'h0);
    check("R6 result", result, 32'h8000_0000);
    drive('0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    check("R7 epc loaded", epc_out, 32'h0000_0400);
    check("R6 pulse ends", {31'b0, exc_req}, 32'h0);

    // R7 trapping op without overflow
    drive(32'h5, 32'h3, 1'b1, 1'b1, 32'h0000_0500, 1'b1, 1'b1);
    check("R7 no exc", {31'b0, exc_req}, 32'h0);
    check("R7 wr_en", {31'b0, wr_en}, 32'h1);
    drive('0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    check("R7 epc held", epc_out, 32'h0000_0400);

    // R10 stalled trapping overflow
    drive(32'h8000_0000, 32'h1, 1'b1, 1'b1, 32'h0000_0600, 1'b1, 1'b0);
    check("R10 in_ready", {31'b0, in_ready}, 32'h0);
    check("R10 no exc", {31'b0, exc_req}, 32'h0);
    drive(32'h8000_0000, 32'h1, 1'b1, 1'b1, 32'h0000_0600, 1'b1, 1'b0);
    check("R10 epc held", epc_out, 32'h0000_0400);
    // R10 released: now accepted
    drive(32'h8000_0000, 32'h1, 1'b1, 1'b1, 32'h0000_0600, 1'b1, 1'b1);
    check("R10 exc on accept", {31'b0, exc_req}, 32'h1);
    drive('0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    check("R7 epc second", epc_out, 32'h0000_0600);

    check("R9 handler", handler_pc, 32'h8000_0180);

    // R8 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 epc cleared", epc_out, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R8 epc after release", epc_out, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule